// File: doc/BRIEF.md
# Memory Region Routing Decoder

This block decides, for each memory access on a 20-bit address space, whether the access is served by memory on the system board or sent out to the expansion I/O channel. An access is one cycle with `acc_valid` high. It carries an address and a flag that marks it as a read or a write. One clock later the decoder presents a single routing bit on `route_ext`, where 1 means the channel and 0 means the board.

Configuration comes in as plain bit vectors, which a register port elsewhere drives. The span from 0x40000 up to 0xBFFFF is split into 16KB blocks, and each block has its own routing bit. Each 16KB block in the top 256KB also has its own routing bit. When that bit is clear, the block follows a shadow control byte. The byte holds a separate read choice and write choice for each 64KB group. Everything below 0x40000 always stays on the board.

No routing decision is cached. Every access is decoded from the configuration values present in its own strobe cycle.

Top module: `mem_route_decoder`

## Requirements
- R1: While `rst_n` is low, `route_valid` and `route_ext` are both 0.
- R2: `route_valid` is 1 in the cycle after a cycle with `acc_valid` high, and 0 in the cycle after a cycle with `acc_valid` low.
- R3: Any access to an address below 0x40000 gives `route_ext` = 0, whatever the configuration.
- R4: For an address from 0x40000 to 0xBFFFF, the block index is k = (addr − 0x40000) / 0x4000. If `cfg_low[k]` is 1, both reads and writes give `route_ext` = 1.
- R5: For an address from 0x40000 to 0xBFFFF whose `cfg_low[k]` is 0, both reads and writes give `route_ext` = 0.
- R6: For an address from 0xC0000 to 0xFFFFF, the block index is j = (addr − 0xC0000) / 0x4000. If `cfg_high[j]` is 1, both reads and writes give `route_ext` = 1.
- R7: For a read at 0xC0000 to 0xFFFFF whose `cfg_high[j]` is 0, take the 64KB group g = j / 4. Then `route_ext` = `cfg_boot[3 − g]`, so the group at 0xC0000 uses bit 3 and the group at 0xF0000 uses bit 0.
- R8: For a write at 0xC0000 to 0xFFFFF whose `cfg_high[j]` is 0, `route_ext` = `cfg_boot[7 − g]`, so the group at 0xC0000 uses bit 7 and the group at 0xF0000 uses bit 4.
- R9: `route_ext` keeps its value in any cycle that follows a cycle with `acc_valid` low.
- R10: A change to the configuration inputs in the same cycle as an access takes effect for that access. No earlier decision is reused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 20 | Byte address of the access |
| cfg_boot | input | 8 | Shadow control: read choices in bits 3..0, write choices in bits 7..4 |
| cfg_low | input | 32 | One routing bit per 16KB block from 0x40000 to 0xBFFFF |
| cfg_high | input | 16 | One routing bit per 16KB block from 0xC0000 to 0xFFFFF |
| route_valid | output | 1 | A routing result is present |
| route_ext | output | 1 | 1 = I/O channel, 0 = system board |

## Verification
The bench probes the edges of each window: 0x3FFFF against 0x40000, 0xBFFFF against 0xC0000, and the top byte. A comparison that is off by one would send one block to the wrong side. Every 64KB group is hit with both reads and writes under asymmetric shadow bytes. A reversed group order, or swapped read and write nibbles, would therefore show up as wrong routing in exactly those groups. Back-to-back accesses change the configuration in the strobe cycle, which exposes any stale or cached decision. Idle cycles check that the result does not drift when no access is present.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

   typedef enum logic {
      ROUTE_BOARD   = 1'b0,
      ROUTE_CHANNEL = 1'b1
   } route_e;

   function automatic bit is_pow2(int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/mrd_low_map.sv
module mrd_low_map
   import mrd_pkg::*;
#(
   parameter int IDX_W      = 6,
   parameter int BASE       = 16,
   parameter int BLOCKS     = 32,
   parameter bit ONEHOT_SEL = 1'b1
) (
   input  logic [IDX_W-1:0]  blk_idx,
   input  logic [BLOCKS-1:0] map_bits,
   output logic              hit,
   output route_e            route
);

   localparam int OFS_W = $clog2(BLOCKS);
   localparam logic [IDX_W-1:0] BASE_V = IDX_W'(BASE);

   generate
      if (!is_pow2(BLOCKS) || BLOCKS < 2) begin : g_bad_blocks
         $error("mrd_low_map: BLOCKS must be a power of two >= 2");
      end
      if (BASE + BLOCKS > (1 << IDX_W)) begin : g_bad_span
         $error("mrd_low_map: window exceeds block index range");
      end
   endgenerate

   logic [IDX_W-1:0] rel;
   logic [OFS_W-1:0] ofs;
   logic             pick;

   assign rel = blk_idx - BASE_V;
   assign ofs = OFS_W'(rel);
   assign hit = (int'(blk_idx) >= BASE) && (int'(blk_idx) < BASE + BLOCKS);

   generate
      if (ONEHOT_SEL) begin : g_onehot
         logic [BLOCKS-1:0] sel;
         for (genvar b = 0; b < BLOCKS; b++) begin : g_sel
            assign sel[b] = (ofs == OFS_W'(b));
         end
         assign pick = |(sel & map_bits);
      end else begin : g_mux
         assign pick = map_bits[ofs];
      end
   endgenerate

   assign route = (hit && pick) ? ROUTE_CHANNEL : ROUTE_BOARD;

endmodule

// File: rtl/mrd_high_map.sv
module mrd_high_map
   import mrd_pkg::*;
#(
   parameter int IDX_W        = 6,
   parameter int BASE         = 48,
   parameter int BLOCKS       = 16,
   parameter int GROUP_BLOCKS = 4,
   parameter bit ONEHOT_SEL   = 1'b1
) (
   input  logic [IDX_W-1:0]                       blk_idx,
   input  logic                                   is_write,
   input  logic [BLOCKS-1:0]                      map_bits,
   input  logic [2*(BLOCKS/GROUP_BLOCKS)-1:0]     boot_bits,
   output logic                                   hit,
   output route_e                                 route
);

   localparam int OFS_W  = $clog2(BLOCKS);
   localparam int GROUPS = BLOCKS / GROUP_BLOCKS;
   localparam int GRP_W  = $clog2(GROUPS);
   localparam int GRP_SH = $clog2(GROUP_BLOCKS);
   localparam logic [IDX_W-1:0] BASE_V = IDX_W'(BASE);

   generate
      if (!is_pow2(BLOCKS) || !is_pow2(GROUP_BLOCKS)) begin : g_bad_pow
         $error("mrd_high_map: BLOCKS and GROUP_BLOCKS must be powers of two");
      end
      if (GROUPS < 2) begin : g_bad_groups
         $error("mrd_high_map: need at least two shadow groups");
      end
      if (BASE + BLOCKS > (1 << IDX_W)) begin : g_bad_span
         $error("mrd_high_map: window exceeds block index range");
      end
   endgenerate

   logic [IDX_W-1:0]  rel;
   logic [OFS_W-1:0]  ofs;
   logic [GRP_W-1:0]  grp;
   logic [GROUPS-1:0] rd_ctl;
   logic [GROUPS-1:0] wr_ctl;
   logic              blk_ext;
   logic              shadow_ext;

   assign rel = blk_idx - BASE_V;
   assign ofs = OFS_W'(rel);
   assign grp = GRP_W'(ofs >> GRP_SH);
   assign hit = (int'(blk_idx) >= BASE) && (int'(blk_idx) < BASE + BLOCKS);

   // lowest group takes the highest bit of each nibble
   generate
      for (genvar g = 0; g < GROUPS; g++) begin : g_ctl
         assign rd_ctl[g] = boot_bits[GROUPS-1-g];
         assign wr_ctl[g] = boot_bits[2*GROUPS-1-g];
      end
      if (ONEHOT_SEL) begin : g_onehot
         logic [BLOCKS-1:0] sel;
         for (genvar b = 0; b < BLOCKS; b++) begin : g_sel
            assign sel[b] = (ofs == OFS_W'(b));
         end
         assign blk_ext = |(sel & map_bits);
      end else begin : g_mux
         assign blk_ext = map_bits[ofs];
      end
   endgenerate

   assign shadow_ext = is_write ? wr_ctl[grp] : rd_ctl[grp];
   assign route = (hit && (blk_ext || shadow_ext)) ? ROUTE_CHANNEL : ROUTE_BOARD;

endmodule

// File: rtl/mrd_route_reg.sv
module mrd_route_reg
   import mrd_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   acc_valid,
   input  route_e next_route,
   output logic   route_valid,
   output logic   route_ext
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         route_valid <= 1'b0;
         route_ext   <= 1'b0;
      end else begin
         route_valid <= acc_valid;
         if (acc_valid) begin
            route_ext <= (next_route == ROUTE_CHANNEL);
         end
      end
   end

endmodule

// File: rtl/mem_route_decoder.sv
module mem_route_decoder
   import mrd_pkg::*;
#(
   parameter int ADDR_W       = 20,
   parameter int BLK_SHIFT    = 14,
   parameter int LOW_BASE     = 16,
   parameter int LOW_BLOCKS   = 32,
   parameter int HIGH_BASE    = 48,
   parameter int HIGH_BLOCKS  = 16,
   parameter int GROUP_BLOCKS = 4,
   parameter bit ONEHOT_SEL   = 1'b1
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    acc_valid,
   input  logic                                    acc_write,
   input  logic [ADDR_W-1:0]                       acc_addr,
   input  logic [2*(HIGH_BLOCKS/GROUP_BLOCKS)-1:0] cfg_boot,
   input  logic [LOW_BLOCKS-1:0]                   cfg_low,
   input  logic [HIGH_BLOCKS-1:0]                  cfg_high,
   output logic                                    route_valid,
   output logic                                    route_ext
);

   localparam int IDX_W   = ADDR_W - BLK_SHIFT;
   localparam int GROUPS  = HIGH_BLOCKS / GROUP_BLOCKS;
   localparam int BOOT_W  = 2 * GROUPS;

   generate
      if (ADDR_W > 30 || BLK_SHIFT < 1 || IDX_W < 2) begin : g_bad_addr
         $error("mem_route_decoder: unsupported address or block size");
      end
      if (LOW_BASE + LOW_BLOCKS > HIGH_BASE) begin : g_bad_overlap
         $error("mem_route_decoder: windows overlap");
      end
   endgenerate

   logic [IDX_W-1:0] blk_idx;
   logic             low_hit;
   logic             high_hit;
   route_e           low_route;
   route_e           high_route;
   route_e           next_route;
   logic             unused_ofs_bits;

   assign blk_idx         = acc_addr[ADDR_W-1:BLK_SHIFT];
   assign unused_ofs_bits = ^acc_addr[BLK_SHIFT-1:0];

   mrd_low_map #(
      .IDX_W      (IDX_W),
      .BASE       (LOW_BASE),
      .BLOCKS     (LOW_BLOCKS),
      .ONEHOT_SEL (ONEHOT_SEL)
   ) u_low (
      .blk_idx  (blk_idx),
      .map_bits (cfg_low),
      .hit      (low_hit),
      .route    (low_route)
   );

   mrd_high_map #(
      .IDX_W        (IDX_W),
      .BASE         (HIGH_BASE),
      .BLOCKS       (HIGH_BLOCKS),
      .GROUP_BLOCKS (GROUP_BLOCKS),
      .ONEHOT_SEL   (ONEHOT_SEL)
   ) u_high (
      .blk_idx   (blk_idx),
      .is_write  (acc_write),
      .map_bits  (cfg_high),
      .boot_bits (cfg_boot),
      .hit       (high_hit),
      .route     (high_route)
   );

   // windows are disjoint; anything outside both stays on the board
   always_comb begin
      next_route = ROUTE_BOARD;
      if (low_hit && low_route == ROUTE_CHANNEL)
         next_route = ROUTE_CHANNEL;
      if (high_hit && high_route == ROUTE_CHANNEL)
         next_route = ROUTE_CHANNEL;
   end

   mrd_route_reg u_reg (
      .clk         (clk),
      .rst_n       (rst_n),
      .acc_valid   (acc_valid),
      .next_route  (next_route),
      .route_valid (route_valid),
      .route_ext   (route_ext)
   );

   // ---------------- assertions: byte-address arithmetic view ----------
   localparam int LOW_LO  = LOW_BASE << BLK_SHIFT;
   localparam int LOW_HI  = (LOW_BASE + LOW_BLOCKS) << BLK_SHIFT;
   localparam int HIGH_LO = HIGH_BASE << BLK_SHIFT;
   localparam int HIGH_HI = (HIGH_BASE + HIGH_BLOCKS) << BLK_SHIFT;
   localparam int GRP_BYTES = GROUP_BLOCKS << BLK_SHIFT;
   localparam int LOFS_W  = $clog2(LOW_BLOCKS);
   localparam int HOFS_W  = $clog2(HIGH_BLOCKS);
   localparam int BIDX_W  = $clog2(BOOT_W);

   int                a_addr;
   logic              a_below, a_in_low, a_in_high;
   logic [LOFS_W-1:0] a_lofs;
   logic [HOFS_W-1:0] a_hofs;
   logic [BIDX_W-1:0] a_rd_pick, a_wr_pick;
   logic              a_rd_val, a_wr_val;

   always_comb begin
      a_addr    = int'(acc_addr);
      a_below   = a_addr < LOW_LO;
      a_in_low  = (a_addr >= LOW_LO) && (a_addr < LOW_HI);
      a_in_high = (a_addr >= HIGH_LO) && (a_addr < HIGH_HI);
      a_lofs    = LOFS_W'((a_addr - LOW_LO) / (1 << BLK_SHIFT));
      a_hofs    = HOFS_W'((a_addr - HIGH_LO) / (1 << BLK_SHIFT));
      a_rd_pick = BIDX_W'(GROUPS - 1 - ((a_addr - HIGH_LO) / GRP_BYTES));
      a_wr_pick = BIDX_W'(BOOT_W - 1 - ((a_addr - HIGH_LO) / GRP_BYTES));
      a_rd_val  = cfg_boot[a_rd_pick];
      a_wr_val  = cfg_boot[a_wr_pick];
   end

   // R2
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> route_valid);
   // R2
   idle_novalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> !route_valid);
   // R3
   below_board_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && a_below) |=> !route_ext);
   // R4
   low_set_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && a_in_low && cfg_low[a_lofs]) |=> route_ext);
   // R5
   low_clr_board_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && a_in_low && !cfg_low[a_lofs]) |=> !route_ext);
   // R6
   high_set_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && a_in_high && cfg_high[a_hofs]) |=> route_ext);
   // R7
   high_rd_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && a_in_high && !cfg_high[a_hofs] && !acc_write)
      |=> (route_ext == $past(a_rd_val)));
   // R8
   high_wr_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && a_in_high && !cfg_high[a_hofs] && acc_write)
      |=> (route_ext == $past(a_wr_val)));
   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> $stable(route_ext));

endmodule

// File: tb/mem_route_decoder_tb_top.sv
`timescale 1ns/1ps
module mem_route_decoder_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic        acc_write = 1'b0;
   logic [19:0] acc_addr = '0;
   logic [7:0]  regs [0:15];
   logic [7:0]  cfg_boot;
   logic [31:0] cfg_low;
   logic [15:0] cfg_high;
   logic        route_valid, route_ext;

   always #10 clk = ~clk;

   assign cfg_boot = regs[9];
   assign cfg_low  = {regs[13], regs[12], regs[11], regs[10]};
   assign cfg_high = {regs[15], regs[14]};

   mem_route_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .cfg_boot(cfg_boot), .cfg_low(cfg_low),
      .cfg_high(cfg_high), .route_valid(route_valid), .route_ext(route_ext));

   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;
   bit    r10_mark = 1'b0;
   bit    m_valid = 1'b0;
   bit    m_ext = 1'b0;
   string m_tag = "R1";

   function automatic bit ref_ext(int a, bit wr);
      int c;
      int pair;
      if (a < 'h40000) return 1'b0;
      if (a < 'hC0000) begin
         c = (a - 'h40000) / 'h4000;
         return regs[10 + c / 8][c % 8];
      end
      c = (a - 'hC0000) / 'h4000;
      if (regs[14 + c / 8][c % 8]) return 1'b1;
      pair = (int'(regs[9]) >> (3 - c / 4)) & 'h11;
      return wr ? pair[4] : pair[0];
   endfunction

   function automatic string ref_tag(int a, bit wr);
      int c;
      if (a < 'h40000) return "R3";
      if (a < 'hC0000) begin
         c = (a - 'h40000) / 'h4000;
         return regs[10 + c / 8][c % 8] ? "R4" : "R5";
      end
      c = (a - 'hC0000) / 'h4000;
      if (regs[14 + c / 8][c % 8]) return "R6";
      return wr ? "R8" : "R7";
   endfunction

   // reference model, advanced on every rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_valid <= 1'b0;
         m_ext   <= 1'b0;
         m_tag   <= "R1";
      end else begin
         m_valid <= acc_valid;
         if (acc_valid) begin
            m_ext <= ref_ext(int'(acc_addr), acc_write);
            m_tag <= r10_mark ? "R10" : ref_tag(int'(acc_addr), acc_write);
         end else begin
            m_tag <= "R9";
         end
      end
   end

   task automatic check(bit act, bit exp, string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0b expected=%0b (t=%0t)", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         check(route_valid, m_valid, rst_n ? "R2" : "R1");
         check(route_ext, m_ext, m_tag);
      end
   end

   task automatic acc(int a, bit w);
      @(negedge clk);
      acc_valid <= 1'b1;
      acc_addr  <= 20'(a);
      acc_write <= w;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         acc_valid <= 1'b0;
      end
   endtask

   task automatic set_all(logic [7:0] v);
      for (int i = 0; i < 16; i++) regs[i] = v;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R2 watchdog: actual=running expected=finished");
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      set_all(8'h00);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      idle(2);

      // R3: lowest region ignores every configuration bit
      set_all(8'hFF);
      acc('h00000, 0); acc('h00000, 1); acc('h3FFFF, 0); acc('h20000, 1);
      acc('h40000, 0);
      idle(1);

      // R4 / R5: per-block routing in the middle window, with edges
      set_all(8'h00);
      regs[10] = 8'hA5; regs[11] = 8'h3C; regs[12] = 8'h0F; regs[13] = 8'h81;
      for (int c = 0; c < 32; c++) begin
         acc('h40000 + c * 'h4000 + ((c * 997) & 'h3FFF), c[0]);
         acc('h40000 + c * 'h4000, !c[0]);
      end
      acc('hBFFFF, 0); acc('hBFFFF, 1); acc('h3FFFF, 1);
      idle(2);

      // R6 / R7 / R8: upper window, block bits and shadow nibbles
      regs[14] = 8'h5A; regs[15] = 8'h00;
      for (int p = 0; p < 8; p++) begin
         case (p)
            0: regs[9] = 8'h00; 1: regs[9] = 8'hFF; 2: regs[9] = 8'h88;
            3: regs[9] = 8'h11; 4: regs[9] = 8'h41; 5: regs[9] = 8'h28;
            6: regs[9] = 8'h5A; default: regs[9] = 8'hA5;
         endcase
         for (int c = 0; c < 16; c++) begin
            acc('hC0000 + c * 'h4000 + 'h123, 0);
            acc('hC0000 + c * 'h4000 + 'h3FFF, 1);
         end
      end
      regs[9] = 8'h00; regs[14] = 8'hFF; regs[15] = 8'hFF;
      acc('hC0000, 0); acc('hFFFFF, 1); acc('hBFFFF, 1);
      regs[15] = 8'h00;
      acc('hFFFFF, 0);
      idle(1);

      // R9: result holds across idle cycles (after 1, then after 0)
      regs[10] = 8'h01;
      acc('h40000, 0);
      idle(3);
      acc('h00010, 1);
      idle(3);

      // R10: configuration change in the strobe cycle applies at once
      regs[10] = 8'h00;
      acc('h40000, 0);
      @(negedge clk);
      regs[10] = 8'h01; r10_mark = 1'b1;
      acc_valid <= 1'b1; acc_addr <= 20'h40000; acc_write <= 1'b0;
      @(negedge clk);
      regs[10] = 8'h00;
      acc_valid <= 1'b1; acc_addr <= 20'h40000; acc_write <= 1'b0;
      @(negedge clk);
      regs[9] = 8'h80; regs[14] = 8'h00;
      acc_valid <= 1'b1; acc_addr <= 20'hC0000; acc_write <= 1'b1;
      @(negedge clk);
      regs[9] = 8'h00;
      acc_valid <= 1'b1; acc_addr <= 20'hC0000; acc_write <= 1'b1;
      @(negedge clk);
      r10_mark = 1'b0;
      acc_valid <= 1'b0;
      idle(1);

      // mixed traffic, all requirements
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         if ((i % 23) == 0) begin
            for (int r = 9; r < 16; r++) regs[r] = 8'($urandom);
         end
         acc_valid <= ($urandom_range(0, 3) != 0);
         acc_addr  <= 20'($urandom_range(0, 'hFFFFF));
         acc_write <= 1'($urandom);
      end
      idle(3);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule